// File: doc/BRIEF.md
# Reseeded Chaotic Logistic-Map Generator

This block iterates a digitized chaotic map over a 32-bit state word and produces a fresh pseudo-random state word on every enabled cycle. The map is the logistic recurrence with its gain fixed at four. The multiply by four costs no hardware: the product is shifted left by two bit positions. The term 1−x is the two's-complement negation of the state modulo 2^32. x·(1−x) is taken as the upper half of a full 32×32 product, with both operands read as fractions in [0,1).

A digitized chaotic map falls into fixed points and short cycles. A reseed controller breaks them in two ways:

- It compares each plain next state with the current state.
- It counts iterations against a prime reseed period.

When either condition fires, the word loaded into the state register has its lowest five bits XORed with a fixed non-zero pattern. In that case the iteration counter restarts from zero.

A start command loads a seed and clears the counter. The enable input advances the map by one step per cycle. A valid flag marks each cycle whose state word was just produced by a step.

Top module: `chaos_reseed_gen`

## Requirements
- R1: A synchronous reset sets the state word to 0, clears the iteration counter and holds the valid flag low.
- R2: When start is high at a clock edge, the state takes the seed input and the iteration counter is cleared. Start takes priority over enable. The valid flag is low in the following cycle.
- R3: When neither start nor enable is high at an edge, the state word does not change.
- R4: For a step without a reseed, the new state is computed as follows. Take P = x·((2^32 − x) mod 2^32) as a 64-bit product. The new state is then P[61:32] followed by two zero bits.
- R5: The valid flag is high in exactly the cycle after an edge at which enable was high and start was low, and is low otherwise.
- R6: If the plain next state of R4 equals the current state (a fixed point), the step loads a perturbed word instead. The perturbed word is the plain next state with bits 4:0 XORed with 5'b10101 (0x15). The step also clears the counter.
- R7: Without a fixed point, the counter counts steps since the last start or reseed. Every 19th step (the reseed period) loads the perturbed word of R6 and clears the counter.
- R8: A reseed changes only bits 4:0. Bits 31:5 of the loaded word equal those of the plain next state.
- R9: A zero state is a fixed point, so a step from state 0 yields 0x00000015.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load the seed and clear the iteration counter |
| enable | input | 1 | Advance the map by one step |
| seed | input | 32 | Value loaded by start |
| stateOut | output | 32 | Current state word |
| valid | output | 1 | High in the cycle after a step |

## Verification
A wrong product slice or a wrong shift changes stateOut on the very first step from almost any seed. Hand-worked seeds such as 0.25 and 0.5 expose it exactly. A wrong fixed-point compare or a wrong pattern shows as early as the second step from the seeds 0x40000000 and 0x80000000, which reach a fixed point after one iteration. A counter that is off by one, or that is not cleared on start or on a reseed, leaves the trajectory intact until the 19th step. From that step on, the state diverges from an independently computed trajectory in its low bits, and the error spreads through the whole word within a few further steps.

// File: rtl/chaos_reseed_pkg.sv
package chaos_reseed_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic reseed;
  } lmStrobes_t;
endpackage

// File: rtl/chaos_reseed_dp.sv
module chaos_reseed_dp
  import chaos_reseed_pkg::*;
#(
  parameter int W = 32,
  parameter int PERT_BITS = 5,
  parameter logic [PERT_BITS-1:0] PATTERN = 5'b10101
) (
  input  logic         clk,
  input  logic         rst,
  input  lmStrobes_t   strobes,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state,
  output logic [W-1:0] nextPlain,
  output logic         isFixed
);
  localparam int PW = 2 * W;

  logic [W-1:0]  oneMinus;
  logic [PW-1:0] product;
  logic [W-1:0]  fracProd;
  logic [W-1:0]  perturbed;

  always_comb begin
    oneMinus  = '0 - state;
    product   = {{W{1'b0}}, state} * {{W{1'b0}}, oneMinus};
    fracProd  = product[PW-1:W];
    nextPlain = {fracProd[W-3:0], 2'b00};
    isFixed   = (nextPlain == state);
  end

  for (genvar i = 0; i < W; i++) begin : g_pert
    if (i < PERT_BITS) begin : g_low
      assign perturbed[i] = nextPlain[i] ^ PATTERN[i];
    end else begin : g_high
      assign perturbed[i] = nextPlain[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
    end else if (strobes.load) begin
      state <= seed;
    end else if (strobes.step) begin
      state <= strobes.reseed ? perturbed : nextPlain;
    end
  end
endmodule

// File: rtl/chaos_reseed_ctrl.sv
module chaos_reseed_ctrl
  import chaos_reseed_pkg::*;
#(
  parameter int PERIOD = 19,
  parameter int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             enable,
  input  logic             isFixed,
  output lmStrobes_t       strobes,
  output logic [CNT_W-1:0] cnt,
  output logic             valid
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  always_comb begin
    strobes.load   = start;
    strobes.step   = enable && !start;
    strobes.reseed = strobes.step && (isFixed || cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= strobes.step;
      if (strobes.load || strobes.reseed) begin
        cnt <= '0;
      end else if (strobes.step) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chaos_reseed_gen.sv
module chaos_reseed_gen
  import chaos_reseed_pkg::*;
#(
  parameter int W = 32,
  parameter int PERIOD = 19,
  parameter int PERT_BITS = 5,
  parameter logic [PERT_BITS-1:0] PATTERN = 5'b10101
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         enable,
  input  logic [W-1:0] seed,
  output logic [W-1:0] stateOut,
  output logic         valid
);
  localparam int CNT_W = $clog2(PERIOD);

  lmStrobes_t       strobes;
  logic [W-1:0]     nextPlain;
  logic             isFixed;
  logic [CNT_W-1:0] cnt;

  chaos_reseed_ctrl #(.PERIOD(PERIOD), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst(rst), .start(start), .enable(enable),
    .isFixed(isFixed), .strobes(strobes), .cnt(cnt), .valid(valid)
  );

  chaos_reseed_dp #(.W(W), .PERT_BITS(PERT_BITS), .PATTERN(PATTERN)) i_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .seed(seed),
    .state(stateOut), .nextPlain(nextPlain), .isFixed(isFixed)
  );
endmodule

// File: rtl/chaos_reseed_gen_chk.sv
module chaos_reseed_gen_chk #(
  parameter int W = 32,
  parameter int PERIOD = 19,
  parameter int PERT_BITS = 5,
  parameter logic [PERT_BITS-1:0] PATTERN = 5'b10101,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             enable,
  input logic [W-1:0]     seed,
  input logic [W-1:0]     stateOut,
  input logic             valid,
  input logic [W-1:0]     nextPlain,
  input logic             isFixed,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (stateOut == '0 && !valid && cnt == '0)); // R1
  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    start |=> (stateOut == $past(seed) && cnt == '0 && !valid)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!start && !enable) |=> $stable(stateOut)); // R3
  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    (enable && !start) |=> valid); // R5
  AST_VALID_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!enable || start) |=> !valid); // R5
  AST_FIXED_PERTURBS: assert property (@(posedge clk) disable iff (rst)
    (enable && !start && isFixed) |=>
      (stateOut[PERT_BITS-1:0] == ($past(nextPlain[PERT_BITS-1:0]) ^ PATTERN) && cnt == '0)); // R6
  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (enable && !start && cnt == LAST) |=> (cnt == '0)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R7
  AST_UPPER_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    (enable && !start) |=> (stateOut[W-1:PERT_BITS] == $past(nextPlain[W-1:PERT_BITS]))); // R8
endmodule

bind chaos_reseed_gen chaos_reseed_gen_chk #(
  .W(W), .PERIOD(PERIOD), .PERT_BITS(PERT_BITS), .PATTERN(PATTERN), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .enable(enable), .seed(seed),
  .stateOut(stateOut), .valid(valid), .nextPlain(nextPlain),
  .isFixed(isFixed), .cnt(cnt)
);

// File: tb/test_chaos_reseed_gen.sv
module test_chaos_reseed_gen;
  localparam int CLK_PERIOD = 10;
  localparam int TR = 19;
  localparam logic [31:0] PAT = 32'h15;
  // each entry: seed, state after step 1, state after step 2
  localparam logic [95:0] VEC [0:2] = '{
    {32'h0000_0000, 32'h0000_0015, 32'h0000_0050},
    {32'h8000_0000, 32'h0000_0000, 32'h0000_0015},
    {32'h4000_0000, 32'hC000_0000, 32'hC000_0015}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic enable = 1'b0;
  logic [31:0] seed = '0;
  logic [31:0] stateOut;
  logic valid;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [31:0] mX;
  int mCnt;

  always #(CLK_PERIOD / 2) clk = ~clk;

  chaos_reseed_gen i_chaos_reseed_gen (
    .clk(clk), .rst(rst), .start(start), .enable(enable), .seed(seed),
    .stateOut(stateOut), .valid(valid)
  );

  function automatic logic [31:0] mapPlain(input logic [31:0] x);
    logic [63:0] p;
    p = {32'd0, x} * {32'd0, 32'd0 - x};
    return {p[61:32], 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doStart(input logic [31:0] s, input logic withEn);
    @(negedge clk);
    start = 1'b1; seed = s; enable = withEn;
    @(negedge clk);
    start = 1'b0; enable = 1'b0;
    mX = s; mCnt = 0;
  endtask

  task automatic doStep();
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    enable = 1'b0;
  endtask

  // model step from the requirements: returns 1 when a reseed happens
  function automatic bit modelStep();
    logic [31:0] pl;
    bit rs;
    pl = mapPlain(mX);
    rs = (pl == mX) || (mCnt + 1 == TR);
    mX = rs ? (pl ^ PAT) : pl;
    mCnt = rs ? 0 : mCnt + 1;
    return rs;
  endfunction

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 state after reset", stateOut, 32'h0);
    check("R1 valid after reset", {31'd0, valid}, 32'd0);
    rst = 1'b0;

    // table of hand-computed trajectories: R4, R6, R9
    for (int i = 0; i < 3; i++) begin
      doStart(VEC[i][95:64], 1'b0);
      check("R2 seed load", stateOut, VEC[i][95:64]);
      doStep();
      check("R4/R6/R9 step 1", stateOut, VEC[i][63:32]);
      check("R5 valid after step", {31'd0, valid}, 32'd1);
      doStep();
      check("R4/R6/R9 step 2", stateOut, VEC[i][31:0]);
    end

    // R3: idle cycles hold the state; R5 valid drops
    repeat (4) @(negedge clk);
    check("R3 hold with enable low", stateOut, 32'hC000_0015);
    check("R5 valid low when idle", {31'd0, valid}, 32'd0);

    // R2: start wins over enable
    doStart(32'h1357_9BDF, 1'b1);
    check("R2 start priority", stateOut, 32'h1357_9BDF);
    check("R2 valid low after start", {31'd0, valid}, 32'd0);

    // R7/R8: long run against a model, period reseeds included
    doStart(32'h1234_5678, 1'b0);
    for (int k = 1; k <= 60; k++) begin
      logic [31:0] pl;
      bit rs;
      pl = mapPlain(mX);
      rs = modelStep();
      doStep();
      if (rs) begin
        check("R7 reseed word", stateOut, mX);
        check("R8 upper bits kept", {5'd0, stateOut[31:5]}, {5'd0, pl[31:5]});
      end else begin
        check("R4 plain step", stateOut, mX);
      end
    end

    // R2: start mid-run clears the counter; R7 period counts from there
    for (int k = 0; k < 7; k++) begin
      void'(modelStep());
      doStep();
    end
    doStart(32'h0BAD_F00D, 1'b0);
    for (int k = 1; k <= 25; k++) begin
      void'(modelStep());
      doStep();
      check("R2/R7 counter restart", stateOut, mX);
    end

    // R3 with enable toggling: gaps do not advance the map
    for (int k = 0; k < 5; k++) begin
      void'(modelStep());
      doStep();
      @(negedge clk);
      check("R3 gap hold", stateOut, mX);
    end

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid-run reset", stateOut, 32'h0);
    doStep();
    check("R9 zero escape", stateOut, 32'h15);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule